// File: doc/BRIEF.md
# Delay-Line Power Anomaly Monitor

This block watches the supply of a shared programmable-logic fabric through a tuneable delay-line sensor. Each clock it receives the word captured from the sensor's chain of delay stages. It encodes that word into a propagation depth and smooths the depth with an exponential moving average. It then checks the smoothed value against a programmable safe zone with both a floor and a ceiling. A drop in supply voltage shortens the depth and a rise lengthens it, so the zone catches both directions.

When the smoothed depth leaves the zone, a sticky alarm is raised. The alarm holds off the partial-reconfiguration controller and, if enabled, withdraws a tenant's clock enable until software clears it. Software uses an AXI4-Lite slave to program the bounds, the filter strength and the mode bits. The same port starts a self-calibration that steps the sensor's pre-delay tap until the idle depth falls to the middle of the chain.

Top module: `dline_guard`

## Requirements
- R1: After reset, alarm_o and pr_hold_o are 0, tenant_ce_o is 1, tap_o is 0, CTRL (0x00) reads 0, LOW (0x04) reads 0, HIGH (0x08) reads 128 and SHIFT (0x0C) reads 0.
- R2: The depth of a sample word is the index of its highest set bit plus one, or 0 if no bit is set. It is readable in STATUS (0x10) bits [23:16] once filtered with SHIFT = 0.
- R3: On each clock the average moves by (depth − average) shifted right arithmetically by SHIFT[2:0]. The difference is signed, so a negative step rounds toward minus infinity.
- R4: The average is in the zone when LOW ≤ average ≤ HIGH. Values equal to either bound are in the zone, and a value one step beyond either bound is out. STATUS bit 1 shows the live in-zone state.
- R5: A sample that pushes the average out of the zone at one rising edge makes alarm_o high after the next rising edge, two edges after the sample is presented.
- R6: The alarm (STATUS bit 0) stays set after the average returns to the zone. Writing CTRL with bit 3 set clears it, unless the average is still out of the zone at that edge, in which case it stays set.
- R7: pr_hold_o equals the alarm. tenant_ce_o is 0 only while the alarm is set and CTRL bit 1 (gate enable) is 1.
- R8: Writing CTRL with bit 2 set starts calibration. tap_o restarts at 0 and rises by one each clock while the live depth exceeds 64, then stops at the first tap whose depth is at most 64, or at 31. The busy state reads as CTRL bit 2, the tap reads as STATUS bits [12:8], and no alarm is raised while busy.
- R9: With CTRL bit 0 (enable) clear, an out-of-zone average raises no alarm.
- R10: Writes take the whole word, ignoring byte strobes. Every response is OKAY (0), and a write handshake completes when address and data are both valid and no response is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dl_sample_i | input | 128 | Captured delay-chain word, bit i = stage i |
| tap_o | output | 5 | Pre-delay tap select to the sensor |
| alarm_o | output | 1 | Sticky out-of-zone alarm |
| pr_hold_o | output | 1 | Hold-off to the reconfiguration controller |
| tenant_ce_o | output | 1 | Tenant clock enable |
| s_axi_awaddr | input | 5 | Write address |
| s_axi_awvalid | input | 1 | Write address valid |
| s_axi_awready | output | 1 | Write address ready |
| s_axi_wdata | input | 32 | Write data |
| s_axi_wstrb | input | 4 | Write strobes (ignored) |
| s_axi_wvalid | input | 1 | Write data valid |
| s_axi_wready | output | 1 | Write data ready |
| s_axi_bresp | output | 2 | Write response |
| s_axi_bvalid | output | 1 | Write response valid |
| s_axi_bready | input | 1 | Write response ready |
| s_axi_araddr | input | 5 | Read address |
| s_axi_arvalid | input | 1 | Read address valid |
| s_axi_arready | output | 1 | Read address ready |
| s_axi_rdata | output | 32 | Read data |
| s_axi_rresp | output | 2 | Read response |
| s_axi_rvalid | output | 1 | Read valid |
| s_axi_rready | input | 1 | Read ready |

## Verification
The encoder gets a clean thermometer word and a word with a stray low bit. These show whether the highest stage or a bit count sets the depth. The filter gets a rising step and then a falling step with a shift of two. The falling step tells an arithmetic shift from a logical one and rounding down from truncation toward zero. The zone is driven exactly onto each bound and one step past each, which pins both comparisons and their inclusive edges. A delay model that shortens the depth by four per tap makes calibration stop at one known tap.

// File: rtl/dline_guard.sv
module dline_guard #(
  parameter int DEPTH      = 128,
  parameter int TAPS       = 32,
  parameter int CAL_TARGET = 64,
  parameter int ADDR_W     = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [DEPTH-1:0]   dl_sample_i,
  output logic [$clog2(TAPS)-1:0] tap_o,
  output logic               alarm_o,
  output logic               pr_hold_o,
  output logic               tenant_ce_o,
  input  logic [ADDR_W-1:0]  s_axi_awaddr,
  input  logic               s_axi_awvalid,
  output logic               s_axi_awready,
  input  logic [31:0]        s_axi_wdata,
  input  logic [3:0]         s_axi_wstrb,
  input  logic               s_axi_wvalid,
  output logic               s_axi_wready,
  output logic [1:0]         s_axi_bresp,
  output logic               s_axi_bvalid,
  input  logic               s_axi_bready,
  input  logic [ADDR_W-1:0]  s_axi_araddr,
  input  logic               s_axi_arvalid,
  output logic               s_axi_arready,
  output logic [31:0]        s_axi_rdata,
  output logic [1:0]         s_axi_rresp,
  output logic               s_axi_rvalid,
  input  logic               s_axi_rready
);
  localparam int DW = $clog2(DEPTH + 1);
  localparam int TW = $clog2(TAPS);

  logic [DW-1:0] depth, avg, lo, hi;
  logic [2:0]    k;
  logic          en, gate, busy, alarm;
  logic [TW-1:0] tap;

  always_comb begin
    depth = '0;
    for (int i = 0; i < DEPTH; i++)
      if (dl_sample_i[i]) depth = DW'(i + 1);
  end

  logic signed [DW:0] diff, step, sum;
  assign diff = $signed({1'b0, depth}) - $signed({1'b0, avg});
  assign step = diff >>> k;
  assign sum  = $signed({1'b0, avg}) + step;

  logic in_zone;
  assign in_zone = (avg >= lo) && (avg <= hi);

  logic wr_fire, rd_fire, cal_go, clr;
  assign wr_fire = s_axi_awvalid && s_axi_wvalid && !s_axi_bvalid;
  assign rd_fire = s_axi_arvalid && !s_axi_rvalid;
  assign s_axi_awready = wr_fire;
  assign s_axi_wready  = wr_fire;
  assign s_axi_arready = !s_axi_rvalid;
  assign s_axi_bresp   = 2'b00;
  assign s_axi_rresp   = 2'b00;
  assign cal_go = wr_fire && s_axi_awaddr[4:2] == 3'd0 && s_axi_wdata[2];
  assign clr    = wr_fire && s_axi_awaddr[4:2] == 3'd0 && s_axi_wdata[3];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en <= 1'b0; gate <= 1'b0; lo <= '0; hi <= DW'(DEPTH); k <= '0;
      s_axi_bvalid <= 1'b0;
    end else begin
      if (wr_fire) begin
        s_axi_bvalid <= 1'b1;
        case (s_axi_awaddr[4:2])
          3'd0: begin en <= s_axi_wdata[0]; gate <= s_axi_wdata[1]; end
          3'd1: lo <= s_axi_wdata[DW-1:0];
          3'd2: hi <= s_axi_wdata[DW-1:0];
          3'd3: k  <= s_axi_wdata[2:0];
          default: ;
        endcase
      end else if (s_axi_bready) s_axi_bvalid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      avg <= '0; alarm <= 1'b0; busy <= 1'b0; tap <= '0;
    end else begin
      avg <= sum[DW-1:0];
      if (en && !busy && !in_zone) alarm <= 1'b1;
      else if (clr)                alarm <= 1'b0;
      if (cal_go) begin
        busy <= 1'b1; tap <= '0;
      end else if (busy) begin
        if (depth <= DW'(CAL_TARGET) || tap == TW'(TAPS - 1)) busy <= 1'b0;
        else tap <= tap + 1'b1;
      end
    end
  end

  logic [31:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    case (s_axi_araddr[4:2])
      3'd0: rd_mux[2:0] = {busy, gate, en};
      3'd1: rd_mux[DW-1:0] = lo;
      3'd2: rd_mux[DW-1:0] = hi;
      3'd3: rd_mux[2:0] = k;
      3'd4: begin
        rd_mux[0] = alarm; rd_mux[1] = in_zone;
        rd_mux[8 +: TW] = tap; rd_mux[16 +: DW] = avg;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s_axi_rvalid <= 1'b0; s_axi_rdata <= '0;
    end else if (rd_fire) begin
      s_axi_rvalid <= 1'b1; s_axi_rdata <= rd_mux;
    end else if (s_axi_rready) s_axi_rvalid <= 1'b0;
  end

  assign tap_o       = tap;
  assign alarm_o     = alarm;
  assign pr_hold_o   = alarm;
  assign tenant_ce_o = !(alarm && gate);

  logic unused_ok;
  assign unused_ok = ^{s_axi_wstrb, s_axi_wdata[31:DW], s_axi_awaddr[1:0], s_axi_araddr[1:0]};

  a_r5_alarm_next_edge: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !busy && !in_zone) |=> alarm_o);
  a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (alarm_o && !clr) |=> alarm_o);
  a_r7_gate_needs_alarm: assert property (@(posedge clk) disable iff (!rst_n)
    !tenant_ce_o |-> pr_hold_o);
  a_r8_tap_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !cal_go) |=> $stable(tap_o));
  a_r9_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !alarm_o) |=> !alarm_o);
  a_r10_bvalid_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (s_axi_bvalid && !s_axi_bready) |=> s_axi_bvalid);
endmodule

// File: tb/dline_guard_bench.sv
module dline_guard_bench;
  logic clk = 0, rst_n = 0;
  always #10 clk = ~clk;

  logic [127:0] dl_sample, raw;
  logic [4:0]   tap;
  logic         alarm, pr_hold, tenant_ce;
  logic [4:0]   awaddr = 0, araddr = 0;
  logic         awvalid = 0, wvalid = 0, arvalid = 0;
  logic [31:0]  wdata = 0, rdata;
  logic         awready, wready, bvalid, arready, rvalid;
  logic [1:0]   bresp, rresp;
  logic [7:0]   drv_depth = 0;
  logic         use_model = 0, use_raw = 0;
  int errors = 0, checks = 0;

  function automatic logic [127:0] therm(input int d);
    logic [127:0] v;
    for (int i = 0; i < 128; i++) v[i] = (i < d);
    return v;
  endfunction

  always_comb
    dl_sample = use_raw ? raw : use_model ? therm(120 - 4 * int'(tap)) : therm(int'(drv_depth));

  dline_guard u_dline_guard (
    .clk(clk), .rst_n(rst_n), .dl_sample_i(dl_sample), .tap_o(tap),
    .alarm_o(alarm), .pr_hold_o(pr_hold), .tenant_ce_o(tenant_ce),
    .s_axi_awaddr(awaddr), .s_axi_awvalid(awvalid), .s_axi_awready(awready),
    .s_axi_wdata(wdata), .s_axi_wstrb(4'hf), .s_axi_wvalid(wvalid), .s_axi_wready(wready),
    .s_axi_bresp(bresp), .s_axi_bvalid(bvalid), .s_axi_bready(1'b1),
    .s_axi_araddr(araddr), .s_axi_arvalid(arvalid), .s_axi_arready(arready),
    .s_axi_rdata(rdata), .s_axi_rresp(rresp), .s_axi_rvalid(rvalid), .s_axi_rready(1'b1));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    awaddr = a; wdata = d; awvalid = 1; wvalid = 1;
    while (!(awready && wready)) @(negedge clk);
    @(negedge clk);
    chk("R10 bresp", int'(bresp), 0);
    awvalid = 0; wvalid = 0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    araddr = a; arvalid = 1;
    while (!arready) @(negedge clk);
    @(negedge clk);
    arvalid = 0; d = rdata;
    chk("R10 rresp", int'(rresp), 0);
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    chk("R1 alarm", alarm, 0); chk("R1 pr_hold", pr_hold, 0);
    chk("R1 tenant_ce", tenant_ce, 1); chk("R1 tap", tap, 0);
    rd(5'h00, d); chk("R1 ctrl", d, 0);
    rd(5'h04, d); chk("R1 low", d, 0);
    rd(5'h08, d); chk("R1 high", d, 128);
    rd(5'h0C, d); chk("R1 shift", d, 0);
  endtask

  task automatic t_encode;
    logic [31:0] d;
    raw = '0; raw[5] = 1; raw[40] = 1; use_raw = 1;
    wait_n(2); rd(5'h10, d); chk("R2 highest bit", d[23:16], 41);
    raw = therm(77); wait_n(2); rd(5'h10, d); chk("R2 thermometer", d[23:16], 77);
    raw = '0; wait_n(2); rd(5'h10, d); chk("R2 empty word", d[23:16], 0);
    use_raw = 0; drv_depth = 0;
  endtask

  task automatic t_filter;
    logic [31:0] d;
    wr(5'h0C, 2);
    drv_depth = 64; wait_n(3);
    drv_depth = 37; rd(5'h10, d); chk("R3 rising step", d[23:16], 37);
    drv_depth = 0; wait_n(1);
    drv_depth = 27; rd(5'h10, d); chk("R3 falling step floor", d[23:16], 27);
    wr(5'h0C, 0);
  endtask

  task automatic t_zone;
    logic [31:0] d;
    wr(5'h04, 20); wr(5'h08, 100); wr(5'h00, 1);
    drv_depth = 20; wait_n(3); chk("R4 at low bound", alarm, 0);
    drv_depth = 100; wait_n(3); chk("R4 at high bound", alarm, 0);
    drv_depth = 101; wait_n(1); chk("R5 not after one edge", alarm, 0);
    wait_n(1); chk("R5 set after two edges", alarm, 1);
    chk("R7 pr_hold", pr_hold, 1); chk("R7 ce without gate", tenant_ce, 1);
    drv_depth = 50; wait_n(3); chk("R6 sticky", alarm, 1);
    rd(5'h10, d); chk("R4 in-zone bit", d[1], 1); chk("R6 status alarm", d[0], 1);
    wr(5'h00, 32'h9); chk("R6 cleared", alarm, 0);
    drv_depth = 19; wait_n(3); chk("R4 below low", alarm, 1);
    wr(5'h00, 32'h3); chk("R7 ce gated", tenant_ce, 0);
    wr(5'h00, 32'hB); chk("R6 clear while out", alarm, 1);
    drv_depth = 50; wait_n(2); wr(5'h00, 32'hB);
    chk("R6 clear in zone", alarm, 0); chk("R7 ce restored", tenant_ce, 1);
  endtask

  task automatic t_disabled;
    wr(5'h00, 0); drv_depth = 120; wait_n(4); chk("R9 no alarm when off", alarm, 0);
  endtask

  task automatic t_cal;
    logic [31:0] d;
    wr(5'h08, 50); use_model = 1;
    wr(5'h00, 32'h5);
    rd(5'h00, d); chk("R8 busy", d[2], 1);
    chk("R8 no alarm while busy", alarm, 0);
    wait_n(20);
    chk("R8 tap port", tap, 14);
    rd(5'h10, d); chk("R8 tap field", d[12:8], 14); chk("R8 avg", d[23:16], 64);
    rd(5'h00, d); chk("R8 done", d[2], 0);
    chk("R8 alarm after cal", alarm, 1);
  endtask

  initial begin
    wait_n(3); rst_n = 1; @(negedge clk);
    t_reset; t_encode; t_filter; t_zone; t_disabled; t_cal;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(200000 * 20);
    errors++; checks++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule